// File: doc/BRIEF.md
# Windowed Pulse Frequency Counter

This block measures the rate of a fast digital input. It counts the edges seen on one input pin during a window whose length the host sets in clock cycles. When the window closes, it places the count in a result register and raises a completion flag. From the count and the window length, the host works out the input frequency. The pin goes through a synchronizer before edge detection. A control bit chooses whether rising or falling edges are counted. The input is not filtered in any way.

In single-shot mode, a start request runs exactly one window and the engine then goes idle. In continuous mode, windows follow one another with no gap, and the result register is refreshed at the end of each window until a stop request takes effect. An edge that falls on the cycle where one window hands over to the next belongs to the new window. Every edge therefore lands in exactly one window.

Top module: `pwc_top`

## Requirements
- R1: After reset, `busy`, `done` and `overflow` are 0 and `result` is 0.
- R2: Only edges of the selected polarity are counted: `cfg_falling`=0 counts 0-to-1 transitions of `pulse_in`, and `cfg_falling`=1 counts 1-to-0 transitions. The pin passes through a two-flop synchronizer, and at most one edge is counted per cycle.
- R3: A start request accepted while idle raises `busy` on the next cycle. Each window lasts `cfg_window` clock cycles, and a value of 0 gives a 1-cycle window.
- R4: With `cfg_continuous`=0 at start, exactly one window runs. `busy` then falls, `done` rises and `result` holds that window's count.
- R5: With `cfg_continuous`=1 at start, each window end loads `result`, sets `done` and immediately begins a new window. `result` changes only at a window end.
- R6: In continuous mode no edge is lost or counted twice. An edge on a window's closing cycle is credited to the next window.
- R7: A `stop_req` pulse during a continuous run lets the current window finish, and no further window starts.
- R8: A `start_req` while `busy` is ignored. It neither restarts the window nor changes the latched mode.
- R9: The per-window count saturates at its all-ones value. A window that saturated sets a sticky `overflow` flag.
- R10: `clear_flags` clears `done` and `overflow`. If a window ends in the same cycle, the new flag values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pulse_in | input | 1 | Asynchronous pulse input being measured |
| cfg_window | input | WIN_W | Window length in clock cycles (0 means 1) |
| cfg_continuous | input | 1 | 1 selects back-to-back windows, 0 selects single-shot |
| cfg_falling | input | 1 | 1 counts falling edges, 0 counts rising edges |
| start_req | input | 1 | One-cycle start strobe |
| stop_req | input | 1 | One-cycle request to end a continuous run |
| clear_flags | input | 1 | One-cycle clear of done and overflow |
| busy | output | 1 | A window is in progress |
| done | output | 1 | Sticky flag, set at each window end |
| overflow | output | 1 | Sticky flag, set when a window's count saturated |
| result | output | CNT_W | Count of the last completed window |

## Verification
Single-shot windows are fed evenly spaced pulse bursts placed well inside the window, which confirms that the count is exact. An alternating sequence that begins high has one more falling edge than rising edges, so it shows whether the polarity select takes effect. In continuous mode, a pulse train whose period equals the window length is run at all four phase offsets, so one offset always puts an edge on the handover cycle. Every window must then read exactly one, which separates a dropped or doubled boundary edge from correct handover. A train that is not aligned to the window must sum to the number of pulses sent. A dense burst longer than the count range checks saturation and the overflow flag.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;
endpackage

// File: rtl/pwc_edge_detect.sv
module pwc_edge_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pin_i,
   input  pwc_pkg::edge_sel_e  sel_i,
   output logic                edge_o
);
   localparam int PIPE_W = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("pwc_edge_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // stages 0..SYNC_STAGES-1 synchronize, the last bit holds the previous value
   logic [PIPE_W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[PIPE_W-2:0], pin_i};
   end

   logic now_v, was_v;
   assign now_v = pipe_q[SYNC_STAGES-1];
   assign was_v = pipe_q[SYNC_STAGES];

   always_comb begin
      if (sel_i == pwc_pkg::EDGE_FALL) edge_o = was_v & ~now_v;
      else                             edge_o = now_v & ~was_v;
   end
endmodule

// File: rtl/pwc_window_timer.sv
module pwc_window_timer #(
   parameter int WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             cont_i,
   input  logic [WIN_W-1:0] len_i,
   output logic             busy_o,
   output logic             launch_o,
   output logic             end_o
);
   logic [WIN_W-1:0] remain_q;
   logic [WIN_W-1:0] reload_v;
   logic             busy_q, cont_q, again_v;

   assign reload_v = (len_i == '0) ? '0 : len_i - 1'b1;
   assign launch_o = start_i & ~busy_q;
   assign end_o    = busy_q & (remain_q == '0);
   assign again_v  = end_o & cont_q & ~stop_i;
   assign busy_o   = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         busy_q   <= 1'b0;
         cont_q   <= 1'b0;
      end else if (launch_o) begin
         remain_q <= reload_v;
         busy_q   <= 1'b1;
         cont_q   <= cont_i;
      end else if (busy_q) begin
         if (stop_i) cont_q <= 1'b0;
         if (remain_q == '0) begin
            if (again_v) remain_q <= reload_v;
            else         busy_q   <= 1'b0;
         end else begin
            remain_q <= remain_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwc_pulse_accum.sv
module pwc_pulse_accum #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_i,
   input  logic             busy_i,
   input  logic             launch_i,
   input  logic             end_i,
   output logic [CNT_W-1:0] count_o,
   output logic             sat_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             sat_q;

   // a window opens on its first cycle; an edge there belongs to it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sat_q <= 1'b0;
      end else if (launch_i || end_i) begin
         cnt_q <= edge_i ? CNT_W'(1) : '0;
         sat_q <= 1'b0;
      end else if (busy_i && edge_i) begin
         if (cnt_q == CNT_MAX) sat_q <= 1'b1;
         else                  cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o = cnt_q;
   assign sat_o   = sat_q;
endmodule

// File: rtl/pwc_top.sv
module pwc_top #(
   parameter int CNT_W       = 16,
   parameter int WIN_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pulse_in,
   input  logic [WIN_W-1:0] cfg_window,
   input  logic             cfg_continuous,
   input  logic             cfg_falling,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             clear_flags,
   output logic             busy,
   output logic             done,
   output logic             overflow,
   output logic [CNT_W-1:0] result
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("pwc_top: CNT_W must be at least 2");
      end
      if (WIN_W < 1) begin : g_bad_win
         $error("pwc_top: WIN_W must be at least 1");
      end
   endgenerate

   logic             edge_hit, win_launch, win_end, win_sat;
   logic [CNT_W-1:0] win_count;

   pwc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(pulse_in),
      .sel_i(pwc_pkg::edge_sel_e'(cfg_falling)), .edge_o(edge_hit));

   pwc_window_timer #(.WIN_W(WIN_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(start_req), .stop_i(stop_req),
      .cont_i(cfg_continuous), .len_i(cfg_window), .busy_o(busy),
      .launch_o(win_launch), .end_o(win_end));

   pwc_pulse_accum #(.CNT_W(CNT_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .edge_i(edge_hit), .busy_i(busy),
      .launch_i(win_launch), .end_i(win_end), .count_o(win_count),
      .sat_o(win_sat));

   logic [CNT_W-1:0] result_q;
   logic             done_q, ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         done_q   <= 1'b0;
         ovf_q    <= 1'b0;
      end else if (win_end) begin
         result_q <= win_count;
         done_q   <= 1'b1;
         ovf_q    <= win_sat | (ovf_q & ~clear_flags);
      end else if (clear_flags) begin
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
      end
   end

   assign result   = result_q;
   assign done     = done_q;
   assign overflow = ovf_q;
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_req,
   input logic             clear_flags,
   input logic             busy,
   input logic             done,
   input logic             overflow,
   input logic             win_end,
   input logic [CNT_W-1:0] result
);
   assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_req) |=> busy);

   assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_req) |=> !busy);

   assert_done_follows_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   assert_result_only_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(result));

   assert_sat_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> (result == {CNT_W{1'b1}}));

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !clear_flags) |=> overflow);

   assert_clear_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && clear_flags) |=> (!done && !overflow));
endmodule

bind pwc_top pwc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_req(start_req), .clear_flags(clear_flags),
   .busy(busy), .done(done), .overflow(overflow), .win_end(win_end),
   .result(result));

// File: tb/tb_pwc_top.sv
module tb_pwc_top;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 8;
   localparam int WIN_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pulse_in = 1'b0;
   logic [WIN_W-1:0] cfg_window = '0;
   logic             cfg_continuous = 1'b0;
   logic             cfg_falling = 1'b0;
   logic             start_req = 1'b0;
   logic             stop_req = 1'b0;
   logic             clear_flags = 1'b0;
   logic             busy, done, overflow;
   logic [CNT_W-1:0] result;

   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwc_top #(.CNT_W(CNT_W), .WIN_W(WIN_W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .cfg_window(cfg_window),
      .cfg_continuous(cfg_continuous), .cfg_falling(cfg_falling),
      .start_req(start_req), .stop_req(stop_req), .clear_flags(clear_flags),
      .busy(busy), .done(done), .overflow(overflow), .result(result));

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start(int len, bit cont, bit fall);
      cfg_window = WIN_W'(len); cfg_continuous = cont; cfg_falling = fall;
      start_req = 1'b1;
      tick(1);
      start_req = 1'b0;
   endtask

   task automatic clear_all();
      clear_flags = 1'b1; tick(1); clear_flags = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 5000) begin n++; tick(1); end
   endtask

   task automatic pulse_train(int count, int hi, int lo);
      for (int i = 0; i < count; i++) begin
         pulse_in = 1'b1; tick(hi);
         pulse_in = 1'b0; tick(lo);
      end
   endtask

   task automatic t_reset();
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 overflow", overflow, 0);
      check("R1 result", result, 0);
   endtask

   task automatic t_window_len(int len, int exp_cycles);
      int n = 0;
      do_start(len, 0, 0);
      check("R3 busy after start", busy, 1);
      while (busy && n < 5000) begin n++; tick(1); end
      check("R3 window length", n, exp_cycles);
      check("R4 done after window", done, 1);
      check("R4 empty window result", result, 0);
      clear_all();
      check("R10 done cleared", done, 0);
   endtask

   task automatic t_single_shot();
      do_start(100, 0, 0);
      tick(5);
      pulse_train(10, 3, 3);
      wait_idle();
      check("R2 R4 single-shot count", result, 10);
      check("R4 done set", done, 1);
      check("R9 no overflow", overflow, 0);
      clear_all();
   endtask

   task automatic t_polarity(bit fall, int exp);
      pulse_in = 1'b1; tick(6);
      do_start(100, 0, fall);
      tick(5);
      pulse_in = 1'b0; tick(3); pulse_in = 1'b1; tick(3);
      pulse_in = 1'b0; tick(3); pulse_in = 1'b1; tick(3);
      pulse_in = 1'b0; tick(3);
      wait_idle();
      check(fall ? "R2 falling edges" : "R2 rising edges", result, exp);
      clear_all();
      tick(5);
   endtask

   task automatic t_boundary(int phase);
      int got[30];
      int n = 0;
      pulse_in = 1'b0;
      do_start(4, 1, 0);
      fork
         begin tick(phase); pulse_train(40, 2, 2); end
         begin
            while (n < 30) begin
               tick(1);
               if (done) begin got[n] = result; n++; clear_flags = 1'b1; end
               else clear_flags = 1'b0;
            end
            clear_flags = 1'b0;
         end
      join
      for (int i = 3; i < 30; i++)
         check($sformatf("R6 boundary phase %0d window %0d", phase, i), got[i], 1);
      check("R5 still running", busy, 1);
      stop_req = 1'b1; tick(1); stop_req = 1'b0;
      wait_idle();
      clear_all();
      tick(4);
   endtask

   task automatic t_sum();
      int sum = 0;
      pulse_in = 1'b0;
      do_start(7, 1, 0);
      fork
         begin
            tick(3); pulse_train(20, 2, 3); tick(20);
            stop_req = 1'b1; tick(1); stop_req = 1'b0;
         end
         begin
            int guard = 0;
            do begin
               tick(1); guard++;
               if (done) begin sum += result; clear_flags = 1'b1; end
               else clear_flags = 1'b0;
            end while (busy && guard < 5000);
            tick(1); clear_flags = 1'b0;
         end
      join
      check("R6 continuous sum", sum, 20);
   endtask

   task automatic t_stop();
      int n = 0;
      do_start(20, 1, 0);
      while (busy && n < 5000) begin
         n++;
         stop_req = (n == 30);
         tick(1);
      end
      stop_req = 1'b0;
      check("R7 stop after current window", n, 40);
      check("R7 done at stop", done, 1);
      clear_all();
   endtask

   task automatic t_ignore_start();
      int n = 0;
      do_start(50, 0, 0);
      while (busy && n < 5000) begin
         n++;
         start_req = (n == 20);
         cfg_continuous = (n == 20);
         tick(1);
      end
      start_req = 1'b0; cfg_continuous = 1'b0;
      check("R8 start while busy ignored", n, 50);
      tick(3);
      check("R8 no restart", busy, 0);
      clear_all();
   endtask

   task automatic t_overflow();
      pulse_in = 1'b0;
      do_start(1000, 0, 0);
      tick(5);
      pulse_train(300, 1, 1);
      wait_idle();
      check("R9 saturated result", result, 255);
      check("R9 overflow set", overflow, 1);
      check("R9 done set", done, 1);
      clear_all();
      check("R10 overflow cleared", overflow, 0);
      check("R10 done cleared", done, 0);
      check("R10 result kept", result, 255);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_window_len(5, 5);
      t_window_len(0, 1);
      t_window_len(1, 1);
      t_single_shot();
      t_polarity(1'b0, 2);
      t_polarity(1'b1, 3);
      pulse_in = 1'b0; tick(5);
      for (int p = 0; p < 4; p++) t_boundary(p);
      t_sum();
      t_stop();
      t_ignore_start();
      t_overflow();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule